// File: doc/BRIEF.md
# Scrambler Auto-Synchronization Controller

This block holds a 23-stage self-synchronizing scrambler/descrambler and the sequencer that brings it into step with a far-end scrambler. The detected bits arrive one at a time on a bit strobe. Each bit is tagged as either the sign bit or the magnitude bit of its symbol. When automatic lock is off, the shift register runs as a plain scrambler or as a plain descrambler, chosen by a manual control. When automatic lock is on, the sequencer takes over the mode.

The lock sequence has two phases. In the fill phase, descrambler mode loads the shift register with received bits. In the verify phase, the register runs free in scrambled-ones mode, and its output is compared against the incoming detected bits over a fixed window. When the number of matches rises strictly above a programmable threshold, the controller reports a sync event and stays in scrambled-ones mode. A window that ends without enough matches sets a fail flag and restarts the fill phase.

In two-level signalling only sign bits advance the register; in four-level signalling every bit does.

Top module: `scr_autosync`

## Requirements
- R1: After reset, `phase` is 0 (idle), `sync_irq` and `fail_flag` are low, and `dout_vld` is low.
- R2: With `lock_en` low, `manual_descr`=0 selects scrambler mode (out = in ^ fb, shift in out) and `manual_descr`=1 selects descrambler mode (out = in ^ fb, shift in the received bit). The feedback fb is the XOR of stage 23 and stage 5 when `poly_sel`=0, and of stage 23 and stage 18 when `poly_sel`=1. Stage 1 holds the newest bit, and all stages are zero after reset.
- R3: With `lock_en` high, the manual setting is overridden. The phase goes from idle (0) to fill (1) on the next clock. Fill uses descrambler mode for exactly 23 accepted bits, and on the 23rd it moves to verify (2).
- R4: In verify, the output bit is the scrambled-ones bit (NOT fb, which is also shifted in). It is compared with the detected bit. When the running match count becomes strictly greater than `sync_thresh`, the phase goes to locked (3) on that same edge and `sync_irq` is set.
- R5: If 128 accepted bits pass in verify without the count exceeding the threshold, `fail_flag` is set and the phase returns to fill (1).
- R6: The match count saturates at 128, so a threshold of 128 or more never produces a lock.
- R7: In locked, the register keeps running in scrambled-ones mode for as long as `lock_en` stays high. Whenever `lock_en` is low, the phase is idle (0) after the next clock.
- R8: `sync_irq` stays set until a cycle with `irq_clr` high. `fail_flag` stays set until a cycle with `fail_clr` high.
- R9: With `two_level` high, a bit with `bit_mag`=1 does not advance the register or any phase counter, and its output bit is 0. With `two_level` low, every bit advances.
- R10: Every accepted bit produces `dout_vld` high for exactly one cycle, on the clock after the strobe, with `dout` carrying its output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_en | input | 1 | Enables the automatic lock sequence |
| manual_descr | input | 1 | Mode when lock is off: 1 descrambler, 0 scrambler |
| two_level | input | 1 | 1 selects two-level signalling (sign bits only) |
| poly_sel | input | 1 | Polynomial: 0 taps 5/23, 1 taps 18/23 |
| sync_thresh | input | 8 | Match count that must be exceeded to lock |
| bit_valid | input | 1 | Strobe for one detected bit |
| bit_data | input | 1 | Detected bit value |
| bit_mag | input | 1 | 1 marks the bit as a magnitude bit |
| irq_clr | input | 1 | Write-one clear of `sync_irq` |
| fail_clr | input | 1 | Write-one clear of `fail_flag` |
| dout | output | 1 | Scrambler/descrambler output bit |
| dout_vld | output | 1 | Qualifies `dout` |
| phase | output | 2 | 0 idle, 1 fill, 2 verify, 3 locked |
| sync_irq | output | 1 | Sticky sync-achieved flag |
| fail_flag | output | 1 | Sticky window-failed flag |

## Verification
The bench builds the block with its default parameters: a 23-stage register with taps 5 and 18, a fill length of 23 and a verify window of 128. At these sizes both polynomials can be driven from a far-end scrambled-ones model. Thresholds of 127 and 128 land exactly on the window's last bit and on the saturation point. The same sizes make it practical to step through a full failed window and the refill that follows it, in both two-level and four-level signalling.

// File: rtl/scr_sync_pkg.sv
package scr_sync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FILL   = 2'd1,
    PH_VERIFY = 2'd2,
    PH_LOCKED = 2'd3
  } sync_phase_e;

  typedef enum logic [1:0] {
    MD_SCR   = 2'd0,
    MD_DESCR = 2'd1,
    MD_ONES  = 2'd2
  } lfsr_mode_e;

endpackage

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core
  import scr_sync_pkg::*;
#(
  parameter int LEN    = 23,
  parameter int TAP_LO = 5,
  parameter int TAP_HI = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       skip,
  input  lfsr_mode_e mode,
  input  logic       poly_sel,
  input  logic       din,
  output logic       gen_bit,
  output logic       dout,
  output logic       dout_vld
);

  logic [LEN-1:0] sr_q, sr_d;
  logic           fb;
  logic           out_c;
  logic           shin;
  logic           dout_d;
  logic           vld_d;
  logic           dout_en;

  // feedback taps: stage k lives at sr_q[k-1]
  always_comb begin
    fb = (poly_sel ? sr_q[TAP_HI-1] : sr_q[TAP_LO-1]) ^ sr_q[LEN-1];
  end

  always_comb begin
    out_c = din ^ fb;
    shin  = out_c;
    unique case (mode)
      MD_DESCR: begin
        out_c = din ^ fb;
        shin  = din;
      end
      MD_ONES: begin
        out_c = ~fb;
        shin  = ~fb;
      end
      default: begin
        out_c = din ^ fb;
        shin  = din ^ fb;
      end
    endcase
  end

  assign gen_bit = out_c;

  always_comb begin
    sr_d    = sr_q;
    dout_en = upd | skip;
    dout_d  = 1'b0;
    vld_d   = upd | skip;
    if (upd) begin
      sr_d   = {sr_q[LEN-2:0], shin};
      dout_d = out_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      dout     <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= vld_d;
      if (upd)     sr_q <= sr_d;
      if (dout_en) dout <= dout_d;
    end
  end

endmodule

// File: rtl/scr_sync_seq.sv
module scr_sync_seq
  import scr_sync_pkg::*;
#(
  parameter int FILL_LEN = 23,
  parameter int WIN_LEN  = 128,
  parameter int THR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en,
  input  logic             manual_descr,
  input  logic             upd,
  input  logic             match,
  input  logic [THR_W-1:0] thresh,
  output sync_phase_e      phase,
  output lfsr_mode_e       mode,
  output logic             lock_evt,
  output logic             fail_evt
);

  localparam int FC_W = $clog2(FILL_LEN);
  localparam int WC_W = $clog2(WIN_LEN);
  localparam int MC_W = $clog2(WIN_LEN + 1);
  localparam int CW   = ((MC_W > THR_W) ? MC_W : THR_W) + 1;

  sync_phase_e     ph_q, ph_d;
  logic [FC_W-1:0] fill_q, fill_d;
  logic [WC_W-1:0] win_q, win_d;
  logic [MC_W-1:0] mcnt_q, mcnt_d;
  logic [MC_W-1:0] mcnt_inc;
  logic            fill_en, win_en, mcnt_en;

  // saturating match accumulator
  always_comb begin
    if (mcnt_q == MC_W'(WIN_LEN)) mcnt_inc = mcnt_q;
    else                          mcnt_inc = mcnt_q + MC_W'(match);
  end

  always_comb begin
    ph_d     = ph_q;
    fill_d   = fill_q;
    win_d    = win_q;
    mcnt_d   = mcnt_q;
    lock_evt = 1'b0;
    fail_evt = 1'b0;
    if (!lock_en) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d   = PH_FILL;
          fill_d = '0;
        end
        PH_FILL: begin
          if (upd) begin
            if (fill_q == FC_W'(FILL_LEN - 1)) begin
              ph_d   = PH_VERIFY;
              win_d  = '0;
              mcnt_d = '0;
            end else begin
              fill_d = fill_q + 1'b1;
            end
          end
        end
        PH_VERIFY: begin
          if (upd) begin
            if (CW'(mcnt_inc) > CW'(thresh)) begin
              ph_d     = PH_LOCKED;
              lock_evt = 1'b1;
              mcnt_d   = mcnt_inc;
            end else if (win_q == WC_W'(WIN_LEN - 1)) begin
              ph_d     = PH_FILL;
              fill_d   = '0;
              fail_evt = 1'b1;
            end else begin
              win_d  = win_q + 1'b1;
              mcnt_d = mcnt_inc;
            end
          end
        end
        default: ph_d = PH_LOCKED;
      endcase
    end
  end

  assign fill_en = (fill_d != fill_q);
  assign win_en  = (win_d != win_q);
  assign mcnt_en = (mcnt_d != mcnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      fill_q <= '0;
      win_q  <= '0;
      mcnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (fill_en) fill_q <= fill_d;
      if (win_en)  win_q  <= win_d;
      if (mcnt_en) mcnt_q <= mcnt_d;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_FILL:             mode = MD_DESCR;
      PH_VERIFY, PH_LOCKED: mode = MD_ONES;
      default:             mode = manual_descr ? MD_DESCR : MD_SCR;
    endcase
  end

  assign phase = ph_q;

endmodule

// File: rtl/scr_sticky_bit.sv
module scr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

endmodule

// File: rtl/scr_autosync.sv
module scr_autosync
  import scr_sync_pkg::*;
#(
  parameter int LFSR_LEN = 23,
  parameter int TAP_LO   = 5,
  parameter int TAP_HI   = 18,
  parameter int FILL_LEN = 23,
  parameter int WIN_LEN  = 128,
  parameter int THR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en,
  input  logic             manual_descr,
  input  logic             two_level,
  input  logic             poly_sel,
  input  logic [THR_W-1:0] sync_thresh,
  input  logic             bit_valid,
  input  logic             bit_data,
  input  logic             bit_mag,
  input  logic             irq_clr,
  input  logic             fail_clr,
  output logic             dout,
  output logic             dout_vld,
  output logic [1:0]       phase,
  output logic             sync_irq,
  output logic             fail_flag
);

  logic [1:0]  rs_q;
  logic        rst_sync_n;
  logic        upd, skip;
  logic        gen_bit;
  lfsr_mode_e  mode;
  sync_phase_e ph;
  logic        lock_evt, fail_evt;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // magnitude bits are dropped in two-level signalling
  assign skip = bit_valid & two_level & bit_mag;
  assign upd  = bit_valid & ~skip;

  scr_lfsr_core #(
    .LEN    (LFSR_LEN),
    .TAP_LO (TAP_LO),
    .TAP_HI (TAP_HI)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd      (upd),
    .skip     (skip),
    .mode     (mode),
    .poly_sel (poly_sel),
    .din      (bit_data),
    .gen_bit  (gen_bit),
    .dout     (dout),
    .dout_vld (dout_vld)
  );

  scr_sync_seq #(
    .FILL_LEN (FILL_LEN),
    .WIN_LEN  (WIN_LEN),
    .THR_W    (THR_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .lock_en      (lock_en),
    .manual_descr (manual_descr),
    .upd          (upd),
    .match        (gen_bit == bit_data),
    .thresh       (sync_thresh),
    .phase        (ph),
    .mode         (mode),
    .lock_evt     (lock_evt),
    .fail_evt     (fail_evt)
  );

  scr_sticky_bit u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (lock_evt),
    .clr   (irq_clr),
    .q     (sync_irq)
  );

  scr_sticky_bit u_fail (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (fail_evt),
    .clr   (fail_clr),
    .q     (fail_flag)
  );

  assign phase = ph;

endmodule

// File: rtl/scr_autosync_chk.sv
module scr_autosync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_en,
  input logic       bit_valid,
  input logic       bit_mag,
  input logic       two_level,
  input logic       irq_clr,
  input logic [1:0] phase,
  input logic       sync_irq,
  input logic       fail_flag,
  input logic       dout,
  input logic       dout_vld
);

  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> phase == 2'd0); // R7

  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && lock_en) |=> phase == 2'd3); // R7

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_irq && !irq_clr) |=> sync_irq); // R8

  AST_IRQ_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_irq) |-> phase == 2'd3); // R4

  AST_FAIL_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> phase == 2'd1); // R5

  AST_VERIFY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && $past(phase) != 2'd2) |-> $past(phase) == 2'd1); // R3

  AST_MAG_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && two_level && bit_mag) |=> (dout_vld && !dout)); // R9

  AST_VLD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> dout_vld); // R10

endmodule

bind scr_autosync scr_autosync_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .lock_en   (lock_en),
  .bit_valid (bit_valid),
  .bit_mag   (bit_mag),
  .two_level (two_level),
  .irq_clr   (irq_clr),
  .phase     (phase),
  .sync_irq  (sync_irq),
  .fail_flag (fail_flag),
  .dout      (dout),
  .dout_vld  (dout_vld)
);

// File: tb/scr_autosync_test.sv
`timescale 1ns/1ps
module scr_autosync_test;

  logic       clk;
  logic       rst_n;
  logic       lock_en, manual_descr, two_level, poly_sel;
  logic [7:0] sync_thresh;
  logic       bit_valid, bit_data, bit_mag;
  logic       irq_clr, fail_clr;
  logic       dout, dout_vld;
  logic [1:0] phase;
  logic       sync_irq, fail_flag;

  int n_run;
  int n_bad;
  bit finished;
  logic [22:0] fe;
  logic [22:0] mdl;
  logic [29:0] pat;
  logic [29:0] scr_seen;

  // {poly, two_level, invert, threshold, lock position (0 = no lock)}
  localparam logic [18:0] TBL [6] = '{
    {1'b0, 1'b0, 1'b0, 8'd10,  8'd11},
    {1'b1, 1'b0, 1'b0, 8'd127, 8'd128},
    {1'b0, 1'b1, 1'b0, 8'd0,   8'd1},
    {1'b1, 1'b1, 1'b0, 8'd128, 8'd0},
    {1'b0, 1'b0, 1'b1, 8'd40,  8'd0},
    {1'b1, 1'b0, 1'b0, 8'd63,  8'd64}
  };

  scr_autosync uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_en      (lock_en),
    .manual_descr (manual_descr),
    .two_level    (two_level),
    .poly_sel     (poly_sel),
    .sync_thresh  (sync_thresh),
    .bit_valid    (bit_valid),
    .bit_data     (bit_data),
    .bit_mag      (bit_mag),
    .irq_clr      (irq_clr),
    .fail_clr     (fail_clr),
    .dout         (dout),
    .dout_vld     (dout_vld),
    .phase        (phase),
    .sync_irq     (sync_irq),
    .fail_flag    (fail_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  task automatic send(input logic b, input logic mag);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    bit_mag   = mag;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // far-end scrambled-ones source
  task automatic fe_gen(input logic ps, output logic b);
    logic f;
    f  = (ps ? fe[17] : fe[4]) ^ fe[22];
    b  = ~f;
    fe = {fe[21:0], b};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    logic b;
    logic f;
    n_run = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0;
    lock_en = 1'b0; manual_descr = 1'b0; two_level = 1'b0; poly_sel = 1'b0;
    sync_thresh = 8'd0; bit_valid = 1'b0; bit_data = 1'b0; bit_mag = 1'b0;
    irq_clr = 1'b0; fail_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(phase == 2'd0, "R1 phase", phase, 0);
    chk(!sync_irq && !fail_flag, "R1 flags", {sync_irq, fail_flag}, 0);
    chk(!dout_vld, "R1 dout_vld", dout_vld, 0);

    // table walk: R3 R4 R5 R6 R7 R9 with manual_descr held at 0 (override, R3)
    for (int e = 0; e < 6; e++) begin
      logic       ps, tl, inv;
      logic [7:0] th, at;
      bit         locked;
      {ps, tl, inv, th, at} = TBL[e];
      poly_sel = ps; two_level = tl; sync_thresh = th; manual_descr = 1'b0;
      lock_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(phase == 2'd0, "R7 idle before run", phase, 0);
      fe = 23'h5A5A5 ^ 23'(e * 4099);
      lock_en = 1'b1;
      @(negedge clk);
      chk(phase == 2'd1, "R3 enter fill", phase, 1);
      for (int i = 0; i < 23; i++) begin
        fe_gen(ps, b);
        send(b, 1'b0);
        if (i < 22) chk(phase == 2'd1, "R3 still fill", phase, 1);
        else        chk(phase == 2'd2, "R3 verify after 23", phase, 2);
        if (tl) begin
          send(1'b1, 1'b1);
          chk(dout_vld && !dout, "R9 magnitude output zero", dout, 0);
        end
      end
      locked = 1'b0;
      for (int k = 1; k <= 128; k++) begin
        fe_gen(ps, b);
        send(inv ? ~b : b, 1'b0);
        chk(dout == b, "R4 scrambled-ones output", dout, b);
        if (at != 0 && k == int'(at)) begin
          chk(phase == 2'd3, "R4 locked at strict excess", phase, 3);
          chk(sync_irq, "R4 sync_irq set", sync_irq, 1);
          locked = 1'b1;
          break;
        end else if (k == 128) begin
          chk(phase == 2'd1, "R5 refill after window", phase, 1);
          chk(fail_flag, "R5 R6 fail flag", fail_flag, 1);
        end else begin
          chk(phase == 2'd2 && !sync_irq, "R4 R6 no early lock", phase, 2);
        end
        if (tl) send(~b, 1'b1);
      end
      if (locked) begin
        for (int j = 0; j < 3; j++) begin
          fe_gen(ps, b);
          send(b, 1'b0);
          chk(phase == 2'd3 && dout == b, "R7 stays locked", phase, 3);
        end
        chk(sync_irq, "R8 irq sticky", sync_irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk(!sync_irq, "R8 irq cleared", sync_irq, 0);
      end else begin
        repeat (2) @(negedge clk);
        chk(fail_flag, "R8 fail sticky", fail_flag, 1);
        @(negedge clk); fail_clr = 1'b1;
        @(negedge clk); fail_clr = 1'b0;
        chk(!fail_flag, "R8 fail cleared", fail_flag, 0);
      end
      lock_en = 1'b0;
      @(negedge clk);
      chk(phase == 2'd0, "R7 lock off to idle", phase, 0);
    end

    // R7 drop mid-fill
    poly_sel = 1'b0; two_level = 1'b0;
    lock_en = 1'b1;
    for (int i = 0; i < 5; i++) send(1'b1, 1'b0);
    chk(phase == 2'd1, "R7 mid-fill", phase, 1);
    lock_en = 1'b0;
    @(negedge clk);
    chk(phase == 2'd0, "R7 drop from fill", phase, 0);

    // R2 manual scrambler against model, from reset state
    do_reset();
    poly_sel = 1'b1; manual_descr = 1'b0; two_level = 1'b0;
    pat = 30'h2C93_A5E1;
    mdl = '0;
    for (int i = 0; i < 30; i++) begin
      f = mdl[17] ^ mdl[22];
      b = pat[i] ^ f;
      mdl = {mdl[21:0], b};
      send(pat[i], 1'b0);
      scr_seen[i] = dout;
      chk(dout == b, "R2 scrambler output", dout, b);
      chk(dout_vld, "R10 valid after strobe", dout_vld, 1);
    end
    @(negedge clk);
    chk(!dout_vld, "R10 valid one cycle", dout_vld, 0);

    // R2 descrambler recovers data, R9 four-level advances on magnitude bits
    do_reset();
    manual_descr = 1'b1;
    for (int i = 0; i < 30; i++) begin
      send(scr_seen[i], i[0]);
      chk(dout == pat[i], "R2 R9 descrambler round trip", dout, pat[i]);
    end

    finish_run();
  end

endmodule